// File: doc/BRIEF.md
# Two-Stage Timer Clock Prescaler

This block turns one of four source tick streams into the count enable of a timer. Each source tick is a one-cycle enable on the system clock. A select field picks the source. The selected ticks then pass through two cascaded down-counter dividers. The first divider divides by a power of two (1, 2, 4 or 8). The second divides by any whole ratio from 1 to 8. The output is a one-cycle enable that is only high on a cycle where the selected source ticks. Nothing in the block generates a derived clock.

A clear strobe sets both divider counters to zero and leaves the three setting fields as they are. The first selected tick after clear is released therefore always produces an output tick. After that, output ticks arrive once every (first ratio × second ratio) selected ticks. A change to a divide field is applied when that stage next reloads, so a clear is the way to make a new setting take effect at once.

Top module: `tmr_prescaler`

## Requirements
- R1: `tick_o` is high only in a cycle where the source tick picked by `src_sel_i` (0 to 3 selects `src_tick_i[0]` to `src_tick_i[3]`) is high. Ticks on the other three inputs have no effect on the output or on the counters.
- R2: The first-stage field `div1_sel_i` maps codes 0, 1, 2 and 3 to ratios 1, 2, 4 and 8.
- R3: The second-stage field `div2_sel_i` gives a ratio equal to its value plus one (code 0 gives 1, code 7 gives 8).
- R4: The overall ratio is the product of the two stage ratios. With codes 3 and 7, exactly one output tick is produced for every 64 selected ticks.
- R5: While `clr_i` is high, `tick_o` stays low and both counters are forced to zero. The setting fields are not changed by the clear.
- R6: After a clear, the first selected tick produces an output tick. Later output ticks follow at the programmed ratio.
- R7: When both stage ratios are 1, `tick_o` equals the selected source tick in every cycle.
- R8: A new divide code has no effect until the stage's counter next reaches zero and reloads. The stage that is already counting down finishes its count with the old ratio.
- R9: After reset, the counters are in the same state as after a clear: `tick_o` is low with no source activity, and the first selected tick produces an output tick.
- R10: No more than 64 selected ticks occur without an output tick, whatever sequence of settings is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 4 | One-cycle tick enables, one per source |
| src_sel_i | input | 2 | Source select |
| div1_sel_i | input | 2 | First-stage divide code (ratio = 2^code) |
| div2_sel_i | input | 3 | Second-stage divide code (ratio = code + 1) |
| clr_i | input | 1 | Synchronous clear of both divider counters |
| tick_o | output | 1 | Divided tick enable |

## Verification
The assertions assume that every input is driven to a known level and is stable around each rising clock edge. They also assume that a source tick means "count now" for exactly the cycle in which it is high. Nothing is assumed about how often ticks come or how settings change between them, so the 64-tick gap property is checked under any setting changes. The bench changes its inputs only on falling clock edges. It holds the fields stable through each scenario, except in the one scenario that changes a field mid-count on purpose. Ticks on the unselected inputs are driven at will to exercise the select path.

// File: rtl/tmr_prescaler_pkg.sv
package tmr_prescaler_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_SRC);
  localparam int unsigned D1_W    = 2;
  localparam int unsigned D2_W    = 3;
  // first stage ratio max 2^(2^D1_W - 1); counter holds ratio-1
  localparam int unsigned CNT1_W  = (1 << D1_W) - 1;
  localparam int unsigned CNT2_W  = D2_W;
  localparam int unsigned MAX_GAP = (1 << CNT1_W) * (1 << CNT2_W);

  function automatic logic [CNT1_W-1:0] pre_reload(input logic [D1_W-1:0] code);
    logic [CNT1_W:0] r;
    r = ((CNT1_W+1)'(1) << code) - (CNT1_W+1)'(1);
    return r[CNT1_W-1:0];
  endfunction
endpackage

// File: rtl/tick_mux.sv
module tick_mux #(
  parameter int unsigned N     = 4,
  parameter int unsigned SEL_W = $clog2(N)
) (
  input  logic [N-1:0]     tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [N-1:0] hit;
  for (genvar g = 0; g < N; g++) begin : g_leg
    assign hit[g] = tick_i[g] & (sel_i == SEL_W'(g));
  end
  assign tick_o = |hit;
endmodule

// File: rtl/div_stage.sv
module div_stage #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             zero;

  assign zero = (cnt_q == '0);
  assign en_o = en_i & zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= zero ? reload_i : cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_prescaler_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [D1_W-1:0]    div1_sel_i,
  input  logic [D2_W-1:0]    div2_sel_i,
  input  logic               clr_i,
  output logic               tick_o
);
  logic sel_tick, gated, en1;

  tick_mux #(.N(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .tick_i (src_tick_i),
    .sel_i  (src_sel_i),
    .tick_o (sel_tick)
  );

  assign gated = sel_tick & ~clr_i;

  div_stage #(.CNT_W(CNT1_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .en_i     (gated),
    .reload_i (pre_reload(div1_sel_i)),
    .en_o     (en1)
  );

  div_stage #(.CNT_W(CNT2_W)) u_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .en_i     (en1),
    .reload_i (div2_sel_i),
    .en_o     (tick_o)
  );
endmodule

// File: rtl/tmr_prescaler_chk.sv
module tmr_prescaler_chk
  import tmr_prescaler_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_tick_i,
  input logic [SEL_W-1:0]   src_sel_i,
  input logic               clr_i,
  input logic               tick_o
);
  localparam int unsigned GAP_W = $clog2(MAX_GAP) + 1;
  logic             sel_t;
  logic [GAP_W-1:0] gap_q;

  assign sel_t = src_tick_i[src_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_q <= '0;
    else if (clr_i || tick_o)  gap_q <= '0;
    else if (sel_t)            gap_q <= gap_q + GAP_W'(1);
  end

  AST_TICK_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> sel_t); // R1
  AST_CLEAR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !tick_o); // R5
  AST_FIRST_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && !clr_i && sel_t) |-> tick_o); // R6
  AST_MAX_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_t && !clr_i && gap_q == GAP_W'(MAX_GAP - 1)) |-> tick_o); // R10
  AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < GAP_W'(MAX_GAP)); // R4
endmodule

bind tmr_prescaler tmr_prescaler_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_tick_i (src_tick_i),
  .src_sel_i  (src_sel_i),
  .clr_i      (clr_i),
  .tick_o     (tick_o)
);

// File: tb/sim_tmr_prescaler.sv
module sim_tmr_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic [1:0] src_sel = '0;
  logic [1:0] d1 = '0;
  logic [2:0] d2 = '0;
  logic       clr = 1'b0;
  logic       tick;
  logic [3:0] noise = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tmr_prescaler u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick), .src_sel_i(src_sel),
    .div1_sel_i(d1), .div2_sel_i(d2), .clr_i(clr), .tick_o(tick)
  );

  task automatic report(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one selected tick followed by one idle cycle with noise on other inputs
  task automatic pulse(output logic t, output logic idle_t);
    @(negedge clk);
    src_tick = noise;
    src_tick[src_sel] = 1'b1;
    #1 t = tick;
    @(negedge clk);
    src_tick = noise;
    src_tick[src_sel] = 1'b0;
    #1 idle_t = tick;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    src_tick = '0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // expects output on pulse indices 0, R, 2R, ...
  task automatic run_ratio(input string req, input int c1, input int c2, input int n);
    int ratio, bad_i, act, exp;
    logic t, it;
    bad_i = -1; act = 0; exp = 0;
    d1 = 2'(c1); d2 = 3'(c2);
    ratio = (1 << c1) * (c2 + 1);
    do_clear();
    for (int i = 0; i < n; i++) begin
      pulse(t, it);
      if (bad_i < 0 && (t !== (i % ratio == 0) || it !== 1'b0)) begin
        bad_i = i; act = int'(t); exp = int'(i % ratio == 0);
      end
    end
    report(req, bad_i < 0, act, exp);
  endtask

  task automatic t_reset();
    logic t, it;
    #1 report("R9 idle after reset", tick === 1'b0, int'(tick), 0);
    d1 = 2'd3; d2 = 3'd7;
    pulse(t, it);
    report("R9 first tick after reset", t === 1'b1, int'(t), 1);
  endtask

  task automatic t_select();
    logic t, it;
    int extra;
    src_sel = 2'd2;
    d1 = 2'd0; d2 = 3'd0;
    do_clear();
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      src_tick = 4'b1011;
      #1 if (tick) extra++;
    end
    report("R1 other sources ignored", extra == 0, extra, 0);
    noise = 4'b1011;
    run_ratio("R1 ratio 3 under noise", 0, 2, 12);
    // counters untouched by noise: after a clear plus noise, first select tick fires
    d1 = 2'd1; d2 = 3'd1;
    do_clear();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      src_tick = noise;
    end
    pulse(t, it);
    report("R1 noise leaves counters", t === 1'b1, int'(t), 1);
    noise = '0;
    src_sel = 2'd0;
  endtask

  task automatic t_clear();
    logic t, it;
    int seen;
    d1 = 2'd1; d2 = 3'd2;
    do_clear();
    pulse(t, it);
    pulse(t, it);
    pulse(t, it);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      clr = 1'b1;
      src_tick = 4'b0001;
      #1 if (tick) seen++;
    end
    @(negedge clk);
    clr = 1'b0;
    src_tick = '0;
    report("R5 no tick while clear", seen == 0, seen, 0);
    pulse(t, it);
    report("R6 first tick after clear", t === 1'b1, int'(t), 1);
    seen = 0;
    for (int i = 1; i < 13; i++) begin
      pulse(t, it);
      if (t !== (i % 6 == 0)) seen++;
    end
    report("R5 settings kept across clear", seen == 0, seen, 0);
  endtask

  task automatic t_reload();
    logic t, it;
    logic [7:0] hits;
    d1 = 2'd2; d2 = 3'd0;
    do_clear();
    hits = '0;
    pulse(t, it); hits[0] = t;
    d1 = 2'd0;
    for (int i = 1; i < 8; i++) begin
      pulse(t, it);
      hits[i] = t;
    end
    // old ratio 4 finishes, then ratio 1: ticks at 0,4,5,6,7
    report("R8 change at next reload", hits == 8'b1111_0001, int'(hits), 8'hF1);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_ratio("R7 passthrough", 0, 0, 10);
    run_ratio("R2 first stage /2", 1, 0, 12);
    run_ratio("R2 first stage /4", 2, 0, 16);
    run_ratio("R2 first stage /8", 3, 0, 24);
    run_ratio("R3 second stage /3", 0, 2, 12);
    run_ratio("R3 second stage /5", 0, 4, 15);
    run_ratio("R3 second stage /8", 0, 7, 24);
    run_ratio("R4 product 2x3", 1, 2, 18);
    run_ratio("R4 product 8x8", 3, 7, 130);
    run_ratio("R10 product 4x7", 2, 6, 60);
    t_select();
    t_clear();
    t_reload();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule